// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs interrupt entry for an embedded processor core. Each request carries a cause code, a program-trap qualifier, a 16-bit syndrome, the current program counter and the machine-state word. From these the block chooses which save/restore pair receives the context: standard, critical or machine-check. It forms the return address and the saved state word, and builds the state word the handler will run under. The handler address is a vector-prefix register ORed with an offset register that the cause selects.

Offsets live in two banks. The primary bank has 16 slots, indexed 0 to 15. The extended bank has 6 slots, which stand for indices 32 to 37. Cause codes map onto these slots as follows:

- 0 reset, 1 machine check, 2 data storage, 3 instruction storage, 4 external, 5 alignment, 6 program, 7 FP-unavailable, 8 system call, 9 auxiliary-unit-unavailable, 10 fixed-interval timer, 11 decrementer timer, 12 watchdog, 13 data TLB miss, 14 instruction TLB miss.
- Causes 16 to 21 take extended slots 0 to 5. Cause 16 is the debug cause.
- Cause 15 and causes 22 to 31 map to no index.

Software reaches all offset registers and the prefix through a write port and a combinational read port. External-interrupt gating is done before the request reaches this block, so a request is never queued or retried inside it.

The sequencer has three states: `ST_IDLE`, `ST_VECTOR` and `ST_FAULT`. Its transitions are:

- **accept-legal**: `ST_IDLE` to `ST_VECTOR`, on a request whose cause maps to an index.
- **accept-illegal**: `ST_IDLE` to `ST_FAULT`, on a request whose cause maps to no index.
- **retire**: `ST_VECTOR` to `ST_IDLE`, unconditionally.
- **reject**: `ST_FAULT` to `ST_IDLE`, unconditionally.

Top module: `exc_entry_unit`

## Requirements
- R1: Causes 0 to 14 select primary slot equal to the cause. The handler PC is then {prefix[31:16], 16'h0} ORed with the zero-extended primary offset.
- R2: Causes 16 to 21 select extended slot (cause − 16), which stands for index 32 to 37. The handler PC is the prefix ORed with that extended offset.
- R3: Cause 15 and causes 22 to 31 pulse `vec_err` for one cycle. For such a cause, `vec_valid` stays low and no save strobe asserts.
- R4: Reset (0), watchdog (12) and debug (16) write only the critical pair (`crit_we`). Every other legal cause except machine check writes only the standard pair (`std_we`).
- R5: Machine check (1) asserts `mchk_we` and `crit_we` together with the same return address and saved state. The new state word also has ME (bit 12) and CE (bit 17) cleared.
- R6: Alignment (5), program (6) and FP-unavailable (7) save PC − 4 as the return address. All other causes save the PC unchanged.
- R7: Causes 2, 3, 6, 7, 10, 11 and 12 save the state word with bits 31:16 cleared. Instruction storage (3) then ORs the syndrome into bits 31:16. Other causes save the state word unchanged.
- R8: A program cause with `req_trap` high uses primary slot 15 and sets bit 17 in the saved state word.
- R9: The new state word equals the request state word with these changes: IR (bit 5), DR (bit 4) and RI (bit 1) are cleared; LE (bit 0) takes ILE (bit 16); CM (bit 31) takes ICM (bit 25).
- R10: `req_ready` is high only in `ST_IDLE`. An accepted request yields exactly one pulse of `vec_valid` or `vec_err` on the next clock. During that pulse `req_ready` is low, and a request held high is accepted again only after the pulse.
- R11: The register map places primary offsets at addresses 0 to 15, extended offsets at 16 to 21 and the prefix at 22. Offsets keep write bits 15:4 and read back with bits 3:0 and 31:16 zero. The prefix keeps bits 31:16 and reads back with its low half zero. Unmapped addresses read zero.
- R12: After reset `req_ready` is high, all pulses and strobes are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Unit idle, request accepted this edge |
| req_cause | input | 5 | Cause code |
| req_trap | input | 1 | Program cause is a trap |
| req_syndrome | input | 16 | Syndrome bits for instruction storage |
| req_pc | input | XLEN | PC of next instruction |
| req_msr | input | XLEN | Current machine-state word |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | XLEN | Register write data |
| cfg_rdata | output | XLEN | Register read data (combinational) |
| vec_valid | output | 1 | Vector pulse |
| vec_err | output | 1 | Illegal-cause pulse |
| vec_pc | output | XLEN | Handler address |
| vec_msr | output | XLEN | New machine-state word |
| std_we | output | 1 | Write standard save pair |
| crit_we | output | 1 | Write critical save pair |
| mchk_we | output | 1 | Write machine-check save pair |
| save_ret | output | XLEN | Return address to save |
| save_state | output | XLEN | State word to save |

## Verification
A request is driven on a falling edge and captured at the following rising edge. Every result of that request appears one register later: the handler PC, both state words, the return address, the strobes and the error pulse are all valid from that rising edge until the next one. The bench therefore checks them on the falling edge that follows, and on the falling edge after that it confirms the pulse has ended and `req_ready` has returned. Register read-back is combinational, so it is checked a short delay after the address changes.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned CAUSE_W = 5;
    localparam int unsigned SLOT_W  = 4;
    localparam int unsigned SYN_W   = 16;

    // cause codes
    localparam logic [CAUSE_W-1:0] C_RESET   = 5'd0;
    localparam logic [CAUSE_W-1:0] C_MCHK    = 5'd1;
    localparam logic [CAUSE_W-1:0] C_DSTORE  = 5'd2;
    localparam logic [CAUSE_W-1:0] C_ISTORE  = 5'd3;
    localparam logic [CAUSE_W-1:0] C_ALIGN   = 5'd5;
    localparam logic [CAUSE_W-1:0] C_PROGRAM = 5'd6;
    localparam logic [CAUSE_W-1:0] C_NOFP    = 5'd7;
    localparam logic [CAUSE_W-1:0] C_FIT     = 5'd10;
    localparam logic [CAUSE_W-1:0] C_DECR    = 5'd11;
    localparam logic [CAUSE_W-1:0] C_WDOG    = 5'd12;
    localparam logic [CAUSE_W-1:0] C_LAST_A  = 5'd14;
    localparam logic [CAUSE_W-1:0] C_DEBUG   = 5'd16;
    localparam logic [CAUSE_W-1:0] C_EXT_LO  = 5'd16;

    localparam logic [SLOT_W-1:0]  TRAP_SLOT = 4'd15;

    // machine-state bit positions
    localparam int unsigned B_LE   = 0;
    localparam int unsigned B_RI   = 1;
    localparam int unsigned B_DR   = 4;
    localparam int unsigned B_IR   = 5;
    localparam int unsigned B_ME   = 12;
    localparam int unsigned B_ILE  = 16;
    localparam int unsigned B_CE   = 17;
    localparam int unsigned B_ICM  = 25;
    localparam int unsigned B_CM   = 31;
    localparam int unsigned B_TRAP = 17;

    typedef enum logic [1:0] {
        PAIR_STD  = 2'd0,
        PAIR_CRIT = 2'd1,
        PAIR_MCHK = 2'd2
    } pair_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VECTOR = 2'd1,
        ST_FAULT  = 2'd2
    } state_e;

    typedef struct packed {
        logic              legal;
        logic              bank_b;
        logic [SLOT_W-1:0] slot;
        pair_e             pair;
        logic              rewind;
        logic              clr_hi;
        logic              or_syn;
        logic              trap_bit;
    } route_t;

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
    import exc_pkg::*;
#(
    parameter int unsigned NUM_B = 6
) (
    input  logic [CAUSE_W-1:0] cause,
    input  logic               trap,
    output route_t             route
);

    localparam logic [CAUSE_W-1:0] EXT_HI = CAUSE_W'(int'(C_EXT_LO) + int'(NUM_B) - 1);

    logic [CAUSE_W-1:0] ext_off;

    assign ext_off = cause - C_EXT_LO;

    always_comb begin
        route        = '0;
        route.pair   = PAIR_STD;
        route.legal  = 1'b1;

        if (cause <= C_LAST_A) begin
            route.slot = cause[SLOT_W-1:0];
        end else if (cause >= C_EXT_LO && cause <= EXT_HI) begin
            route.bank_b = 1'b1;
            route.slot   = ext_off[SLOT_W-1:0];
        end else begin
            route.legal = 1'b0;
        end

        unique case (cause)
            C_RESET, C_DEBUG: route.pair = PAIR_CRIT;
            C_MCHK:           route.pair = PAIR_MCHK;
            C_WDOG: begin
                route.pair   = PAIR_CRIT;
                route.clr_hi = 1'b1;
            end
            C_DSTORE, C_FIT, C_DECR: route.clr_hi = 1'b1;
            C_ISTORE: begin
                route.clr_hi = 1'b1;
                route.or_syn = 1'b1;
            end
            C_ALIGN: route.rewind = 1'b1;
            C_PROGRAM, C_NOFP: begin
                route.rewind = 1'b1;
                route.clr_hi = 1'b1;
            end
            default: ;
        endcase

        if (cause == C_PROGRAM && trap) begin
            route.slot     = TRAP_SLOT;
            route.trap_bit = 1'b1;
        end
    end

endmodule

// File: rtl/exc_vector_table.sv
module exc_vector_table
    import exc_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_A    = 16,
    parameter int unsigned NUM_B    = 6,
    parameter int unsigned OFS_W    = 16,
    parameter int unsigned ALIGN    = 4,
    parameter int unsigned PFX_KEEP = 16,
    parameter int unsigned ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [XLEN-1:0]   cfg_wdata,
    output logic [XLEN-1:0]   cfg_rdata,
    input  logic              sel_bank_b,
    input  logic [SLOT_W-1:0] sel_slot,
    output logic [XLEN-1:0]   handler
);

    localparam int unsigned STORE_W  = OFS_W - ALIGN;
    localparam int unsigned PFX_ADDR = NUM_A + NUM_B;
    localparam int unsigned PFX_LOW  = XLEN - PFX_KEEP;

    logic [STORE_W-1:0]  ofs_a [NUM_A];
    logic [STORE_W-1:0]  ofs_b [NUM_B];
    logic [PFX_KEEP-1:0] pfx;
    logic [NUM_A-1:0]    hit_a;
    logic [NUM_B-1:0]    hit_b;
    logic                hit_p;
    logic                unused_low;

    assign unused_low = ^cfg_wdata[ALIGN-1:0];

    for (genvar i = 0; i < NUM_A; i++) begin : g_hit_a
        assign hit_a[i] = cfg_we && (cfg_addr == ADDR_W'(i));
    end
    for (genvar j = 0; j < NUM_B; j++) begin : g_hit_b
        assign hit_b[j] = cfg_we && (cfg_addr == ADDR_W'(NUM_A + j));
    end
    assign hit_p = cfg_we && (cfg_addr == ADDR_W'(PFX_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_A; i++) ofs_a[i] <= '0;
            for (int j = 0; j < NUM_B; j++) ofs_b[j] <= '0;
            pfx <= '0;
        end else begin
            for (int i = 0; i < NUM_A; i++)
                if (hit_a[i]) ofs_a[i] <= cfg_wdata[OFS_W-1:ALIGN];
            for (int j = 0; j < NUM_B; j++)
                if (hit_b[j]) ofs_b[j] <= cfg_wdata[OFS_W-1:ALIGN];
            if (hit_p) pfx <= cfg_wdata[XLEN-1:PFX_LOW];
        end
    end

    // combinational read port
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_A; i++)
            if (cfg_addr == ADDR_W'(i))
                cfg_rdata = XLEN'({ofs_a[i], {ALIGN{1'b0}}});
        for (int j = 0; j < NUM_B; j++)
            if (cfg_addr == ADDR_W'(NUM_A + j))
                cfg_rdata = XLEN'({ofs_b[j], {ALIGN{1'b0}}});
        if (cfg_addr == ADDR_W'(PFX_ADDR))
            cfg_rdata = {pfx, {PFX_LOW{1'b0}}};
    end

    // handler lookup
    logic [STORE_W-1:0] sel_ofs;

    always_comb begin
        sel_ofs = '0;
        if (sel_bank_b) begin
            for (int j = 0; j < NUM_B; j++)
                if (sel_slot == SLOT_W'(j)) sel_ofs = ofs_b[j];
        end else begin
            for (int i = 0; i < NUM_A; i++)
                if (sel_slot == SLOT_W'(i)) sel_ofs = ofs_a[i];
        end
    end

    assign handler = {pfx, {PFX_LOW{1'b0}}} | XLEN'({sel_ofs, {ALIGN{1'b0}}});

endmodule

// File: rtl/exc_context_build.sv
module exc_context_build
    import exc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  route_t           route,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  msr,
    input  logic [SYN_W-1:0] syndrome,
    output logic [XLEN-1:0]  ret_pc,
    output logic [XLEN-1:0]  saved_msr,
    output logic [XLEN-1:0]  entry_msr
);

    localparam int unsigned HI = XLEN - 1;

    logic unused_route;

    assign unused_route = route.legal ^ route.bank_b ^ (^route.slot);

    always_comb begin
        ret_pc = route.rewind ? (pc - XLEN'(4)) : pc;

        saved_msr = msr;
        if (route.clr_hi)   saved_msr[HI -: SYN_W] = '0;
        if (route.or_syn)   saved_msr[HI -: SYN_W] = saved_msr[HI -: SYN_W] | syndrome;
        if (route.trap_bit) saved_msr[B_TRAP] = 1'b1;

        entry_msr       = msr;
        entry_msr[B_IR] = 1'b0;
        entry_msr[B_DR] = 1'b0;
        entry_msr[B_RI] = 1'b0;
        entry_msr[B_LE] = msr[B_ILE];
        entry_msr[B_CM] = msr[B_ICM];
        if (route.pair == PAIR_MCHK) begin
            entry_msr[B_ME] = 1'b0;
            entry_msr[B_CE] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_B    = 6,
    parameter int unsigned OFS_W    = 16,
    parameter int unsigned ALIGN    = 4,
    parameter int unsigned PFX_KEEP = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CAUSE_W-1:0] req_cause,
    input  logic               req_trap,
    input  logic [SYN_W-1:0]   req_syndrome,
    input  logic [XLEN-1:0]    req_pc,
    input  logic [XLEN-1:0]    req_msr,
    input  logic               cfg_we,
    input  logic [4:0]         cfg_addr,
    input  logic [XLEN-1:0]    cfg_wdata,
    output logic [XLEN-1:0]    cfg_rdata,
    output logic               vec_valid,
    output logic               vec_err,
    output logic [XLEN-1:0]    vec_pc,
    output logic [XLEN-1:0]    vec_msr,
    output logic               std_we,
    output logic               crit_we,
    output logic               mchk_we,
    output logic [XLEN-1:0]    save_ret,
    output logic [XLEN-1:0]    save_state
);

    localparam int unsigned NUM_A = 1 << SLOT_W;

    route_t          route;
    logic [XLEN-1:0] handler, ret_pc, saved_msr, entry_msr;
    logic            accept;
    state_e          state_q, state_d;

    logic [XLEN-1:0] pc_q, msr_q, ret_q, save_q;
    pair_e           pair_q;

    exc_cause_decode #(.NUM_B(NUM_B)) u_decode (
        .cause (req_cause),
        .trap  (req_trap),
        .route (route)
    );

    exc_vector_table #(
        .XLEN(XLEN), .NUM_A(NUM_A), .NUM_B(NUM_B), .OFS_W(OFS_W),
        .ALIGN(ALIGN), .PFX_KEEP(PFX_KEEP), .ADDR_W(5)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .sel_bank_b (route.bank_b),
        .sel_slot   (route.slot),
        .handler    (handler)
    );

    exc_context_build #(.XLEN(XLEN)) u_ctx (
        .route     (route),
        .pc        (req_pc),
        .msr       (req_msr),
        .syndrome  (req_syndrome),
        .ret_pc    (ret_pc),
        .saved_msr (saved_msr),
        .entry_msr (entry_msr)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = route.legal ? ST_VECTOR : ST_FAULT;
            ST_VECTOR: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // context capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            msr_q  <= '0;
            ret_q  <= '0;
            save_q <= '0;
            pair_q <= PAIR_STD;
        end else if (accept && route.legal) begin
            pc_q   <= handler;
            msr_q  <= entry_msr;
            ret_q  <= ret_pc;
            save_q <= saved_msr;
            pair_q <= route.pair;
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        vec_valid  = 1'b0;
        vec_err    = 1'b0;
        std_we     = 1'b0;
        crit_we    = 1'b0;
        mchk_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_VECTOR: begin
                vec_valid = 1'b1;
                std_we    = (pair_q == PAIR_STD);
                crit_we   = (pair_q != PAIR_STD);
                mchk_we   = (pair_q == PAIR_MCHK);
            end
            ST_FAULT: vec_err = 1'b1;
            default: ;
        endcase
        vec_pc     = pc_q;
        vec_msr    = msr_q;
        save_ret   = ret_q;
        save_state = save_q;
    end

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned ALIGN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [XLEN-1:0] req_msr,
    input logic            vec_valid,
    input logic            vec_err,
    input logic [XLEN-1:0] vec_pc,
    input logic [XLEN-1:0] vec_msr,
    input logic            std_we,
    input logic            crit_we,
    input logic            mchk_we
);

    p_accept_answers_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (vec_valid || vec_err));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid || vec_err) |=> (!vec_valid && !vec_err && req_ready));

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid || vec_err) |-> !req_ready);

    p_error_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err |-> (!vec_valid && !std_we && !crit_we && !mchk_we));

    p_one_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($countones({std_we, crit_we}) == 1));

    p_strobe_needs_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (std_we || crit_we || mchk_we) |-> vec_valid);

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_we |-> (crit_we && !vec_msr[B_ME] && !vec_msr[B_CE]));

    p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_pc[ALIGN-1:0] == '0));

    p_translation_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (!vec_msr[B_IR] && !vec_msr[B_DR] && !vec_msr[B_RI]));

    p_endian_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_msr[B_LE] == $past(req_msr[B_ILE])
                       && vec_msr[B_CM] == $past(req_msr[B_ICM])));

endmodule

bind exc_entry_unit exc_entry_checker #(.XLEN(XLEN), .ALIGN(ALIGN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_msr   (req_msr),
    .vec_valid (vec_valid),
    .vec_err   (vec_err),
    .vec_pc    (vec_pc),
    .vec_msr   (vec_msr),
    .std_we    (std_we),
    .crit_we   (crit_we),
    .mchk_we   (mchk_we)
);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_trap = 1'b0;
    logic [4:0]  req_cause = '0;
    logic [15:0] req_syndrome = '0;
    logic [31:0] req_pc = '0, req_msr = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        vec_valid, vec_err, std_we, crit_we, mchk_we;
    logic [31:0] vec_pc, vec_msr, save_ret, save_state;

    exc_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cause(req_cause), .req_trap(req_trap), .req_syndrome(req_syndrome),
        .req_pc(req_pc), .req_msr(req_msr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vec_valid(vec_valid),
        .vec_err(vec_err), .vec_pc(vec_pc), .vec_msr(vec_msr), .std_we(std_we),
        .crit_we(crit_we), .mchk_we(mchk_we), .save_ret(save_ret), .save_state(save_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ofs_a(input int i);
        return 32'h20 + 32'(i) * 32'h100;
    endfunction

    function automatic logic [31:0] exp_ofs_b(input int j);
        return 32'h9A70 + 32'(j) * 32'h100;
    endfunction

    task automatic cfg_write(input int a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_one(input int cause, input bit trap, input logic [31:0] msr);
        logic [31:0] pc, e_pc, e_ret, e_sav, e_new;
        logic [15:0] syn;
        logic [2:0]  e_we;
        bit legal, ext;
        string t;
        chk("R10 ready before request", {31'b0, req_ready}, 32'd1);
        chk("R10 no pulse while idle", {30'b0, vec_valid, vec_err}, 32'd0);
        pc  = 32'h1000_0004 + 32'(cause) * 32'h100;
        syn = 16'hA500 + 16'(cause);
        req_valid = 1'b1; req_cause = 5'(cause); req_trap = trap;
        req_syndrome = syn; req_pc = pc; req_msr = msr;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;

        ext   = (cause >= 16 && cause <= 21);
        legal = (cause <= 14) || ext;
        if (!legal) begin
            chk("R3 error pulse", {31'b0, vec_err}, 32'd1);
            chk("R3 no vector", {28'b0, vec_valid, std_we, crit_we, mchk_we}, 32'd0);
        end else begin
            t = ext ? "R2 handler" : ((cause == 6 && trap) ? "R8 handler" : "R1 handler");
            if (ext)                    e_pc = 32'hABCD_0000 | exp_ofs_b(cause - 16);
            else if (cause == 6 && trap) e_pc = 32'hABCD_0000 | exp_ofs_a(15);
            else                        e_pc = 32'hABCD_0000 | exp_ofs_a(cause);
            chk("R10 vector pulse", {31'b0, vec_valid}, 32'd1);
            chk(t, vec_pc, e_pc);

            if (cause == 1)                                    e_we = 3'b011;
            else if (cause == 0 || cause == 12 || cause == 16) e_we = 3'b010;
            else                                               e_we = 3'b100;
            chk((cause == 1) ? "R5 pair strobes" : "R4 pair strobes",
                {29'b0, std_we, crit_we, mchk_we}, {29'b0, e_we});

            e_ret = (cause == 5 || cause == 6 || cause == 7) ? pc - 32'd4 : pc;
            chk("R6 return address", save_ret, e_ret);

            e_sav = msr;
            if (cause == 2 || cause == 3 || cause == 6 || cause == 7 ||
                cause == 10 || cause == 11 || cause == 12) e_sav[31:16] = 16'h0;
            if (cause == 3) e_sav[31:16] = syn;
            if (cause == 6 && trap) e_sav[17] = 1'b1;
            chk((cause == 6 && trap) ? "R8 saved state" : "R7 saved state", save_state, e_sav);

            e_new = msr;
            e_new[5] = 1'b0; e_new[4] = 1'b0; e_new[1] = 1'b0;
            e_new[0] = msr[16]; e_new[31] = msr[25];
            if (cause == 1) begin e_new[12] = 1'b0; e_new[17] = 1'b0; end
            chk((cause == 1) ? "R5 new state" : "R9 new state", vec_msr, e_new);
        end
        chk("R10 not ready during pulse", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'h0000_8000;
        pats[1] = 32'h8201_1037;
        pats[2] = 32'h7DFE_EFC8;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R12 outputs quiet", {27'b0, vec_valid, vec_err, std_we, crit_we, mchk_we}, 32'd0);
        for (int a = 0; a < 23; a++) begin
            cfg_addr = 5'(a); #1;
            chk("R12 register zero", cfg_rdata, 32'd0);
        end

        // R11 programming and read-back
        for (int i = 0; i < 16; i++) cfg_write(i, 32'hFFFF_002F | (32'(i) << 8));
        for (int j = 0; j < 6; j++)  cfg_write(16 + j, 32'h1234_9A7F + (32'(j) << 8));
        cfg_write(22, 32'hABCD_1234);
        for (int i = 0; i < 16; i++) begin
            cfg_addr = 5'(i); #1; chk("R11 primary readback", cfg_rdata, exp_ofs_a(i));
        end
        for (int j = 0; j < 6; j++) begin
            cfg_addr = 5'(16 + j); #1; chk("R11 extended readback", cfg_rdata, exp_ofs_b(j));
        end
        cfg_addr = 5'd22; #1; chk("R11 prefix readback", cfg_rdata, 32'hABCD_0000);
        cfg_addr = 5'd27; #1; chk("R11 unmapped reads zero", cfg_rdata, 32'd0);
        @(negedge clk);

        // sweep every cause code, trap qualifier and state pattern
        for (int c = 0; c < 32; c++)
            for (int tr = 0; tr < 2; tr++)
                for (int p = 0; p < 3; p++)
                    run_one(c, tr[0], pats[p]);

        // R10 held request: one pulse, then idle, then accepted again
        req_valid = 1'b1; req_cause = 5'd4; req_trap = 1'b0; req_msr = pats[1];
        @(posedge clk); @(negedge clk);
        chk("R10 held first pulse", {31'b0, vec_valid}, 32'd1);
        @(negedge clk);
        chk("R10 held gap", {30'b0, vec_valid, req_ready}, 32'd1);
        @(negedge clk);
        chk("R10 held second pulse", {31'b0, vec_valid}, 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 back to idle", {30'b0, vec_valid, req_ready}, 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule